// File: doc/BRIEF.md
# Configuration Address/Data Port Decoder

This block sits on a simple host I/O port bus and provides the classic two-port route into configuration space. A 32-bit selector register, reached as one full dword at I/O 0x0CF8, holds an enable flag and the bus, device, function and dword register number of the next configuration access. A four-byte data window at I/O 0x0CFC–0x0CFF then turns host reads and writes into configuration reads and writes. The byte lanes of the access come from the host byte enables.

Each host access is classified in one of four ways. It may go to the selector. It may be claimed by the local device's small register file. It may be sent downstream as a configuration cycle carrying the latched selector fields. Or it may be sent downstream as a plain I/O cycle. The local register file has a read-only identity word, a few writable test words, and reserved space. The reserved space always completes, reads as zero and ignores writes.

Top module: `cfg_mech_decoder`

## Requirements
- R1: After reset the selector reads 0x00000000, so the window is disabled. Every test word holds TEST_RESET, and no output pulse is active.
- R2: A write to 0x0CF8 with all four byte enables set updates the selector. A read of it returns the stored value with bits 30:24 and 1:0 forced to zero. The field layout is: enable at bit 31, bus at 23:16, device at 15:11, function at 10:8, dword number at 7:2.
- R3: An access to the 0x0CF8 dword with fewer than four byte enables is not claimed. It produces a downstream I/O pulse carrying the same address, byte enables, direction and write data, and it leaves the selector unchanged.
- R4: While the enable bit is clear, any window access (0x0CFC dword, non-zero byte enables) is forwarded as a downstream I/O cycle.
- R5: While enabled with bus 0 and device equal to LOCAL_DEV, a window access is claimed locally. The dword number selects the word, and read data appears only in the lanes whose byte enable is set (bit k of the enables selects data bits 8k+7:8k). All other lanes read zero.
- R6: While enabled with a bus other than 0 or a device other than LOCAL_DEV, a window access produces a downstream configuration pulse. The pulse carries the latched bus, device, function and dword number together with the host byte enables, direction and write data.
- R7: Local words at function 0 that are neither the identity word nor a test word, and every local word at functions 1–7, read zero for any access size. Writes to them have no effect.
- R8: Local function 0 dword numbers TEST_BASE to TEST_BASE+NUM_TEST-1 are test words. A write updates only the lanes whose byte enable is set.
- R9: Local function 0 dword number 0 reads ID_VALUE, and writes to it have no effect.
- R10: Each access is answered by a one-cycle ready pulse on the clock edge that samples the request. Read data is valid in that same cycle, and it is zero for any access that is forwarded downstream.
- R11: Any access to an I/O dword other than 0x0CF8 and 0x0CFC, or with all byte enables clear, is forwarded as a downstream I/O cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| io_req | input | 1 | Host access strobe, one cycle per access |
| io_wr | input | 1 | 1 = write, 0 = read |
| io_addr | input | ADDR_W | Host I/O byte address; bits above 1 select the dword |
| io_be | input | 4 | Byte enables of the addressed dword |
| io_wdata | input | 32 | Host write data |
| io_rdy | output | 1 | One-cycle completion pulse |
| io_rdata | output | 32 | Read data, valid with io_rdy |
| ds_io_req | output | 1 | Downstream plain I/O cycle pulse |
| ds_cfg_req | output | 1 | Downstream configuration cycle pulse |
| ds_wr | output | 1 | Direction of the downstream cycle |
| ds_addr | output | ADDR_W | Host address of the forwarded cycle |
| ds_be | output | 4 | Byte enables of the forwarded cycle |
| ds_wdata | output | 32 | Write data of the forwarded cycle |
| ds_bus | output | 8 | Bus number of a configuration cycle |
| ds_dev | output | 5 | Device number of a configuration cycle |
| ds_fn | output | 3 | Function number of a configuration cycle |
| ds_reg | output | 6 | Dword number of a configuration cycle |

## Verification
The bench sweeps every partial byte-enable pattern against the selector port. A decoder that latched partial writes would corrupt the selector, and one that swallowed them would lose the downstream I/O pulse. It walks all 64 local dword numbers with mixed lane enables, then reads them back, to catch a reserved word that stores data, a writable identity word, or a test word that merges the wrong lanes. It also sweeps every device number on several buses, with the local device on a non-zero bus and on bus 0, and it writes selector patterns with reserved bits set. A design that compared the wrong fields would claim cycles that belong downstream, and one that kept reserved bits would read them back as ones.

// File: rtl/cfgm_pkg.sv
package cfgm_pkg;

   typedef enum logic [2:0] {
      ACC_NONE,
      ACC_SEL,
      ACC_LOCAL,
      ACC_DS_CFG,
      ACC_DS_IO
   } acc_kind_e;

   typedef struct packed {
      logic       en;
      logic [7:0] bus;
      logic [4:0] dev;
      logic [2:0] fn;
      logic [5:0] regn;
   } cfg_sel_t;

   function automatic cfg_sel_t split_sel(input logic [31:0] v);
      cfg_sel_t s;
      s.en   = v[31];
      s.bus  = v[23:16];
      s.dev  = v[15:11];
      s.fn   = v[10:8];
      s.regn = v[7:2];
      return s;
   endfunction

   function automatic logic [31:0] lane_mask(input logic [3:0] be);
      logic [31:0] m;
      for (int k = 0; k < 4; k++) begin
         m[k*8 +: 8] = {8{be[k]}};
      end
      return m;
   endfunction

endpackage

// File: rtl/cfgm_sel_reg.sv
module cfgm_sel_reg
   import cfgm_pkg::*;
#(
   parameter int unsigned DATA_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [DATA_W-1:0] wdata,
   output cfg_sel_t          sel,
   output logic [DATA_W-1:0] rd_word
);

   localparam logic [DATA_W-1:0] KEEP_MASK = DATA_W'(32'h80FF_FFFC);

   generate
      if (DATA_W != 32) begin : g_bad_width
         initial $fatal(1, "cfgm_sel_reg: DATA_W must be 32");
      end
   endgenerate

   logic [DATA_W-1:0] q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         q <= '0;
      end else if (wr_en) begin
         q <= wdata & KEEP_MASK;
      end
   end

   assign rd_word = q;
   assign sel     = split_sel(q[31:0]);

   // R3: the selector moves only on a full-dword write strobe
   a_r3_sel_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_en |=> $stable(q));

endmodule

// File: rtl/cfgm_host_decode.sv
module cfgm_host_decode
   import cfgm_pkg::*;
#(
   parameter int unsigned       ADDR_W    = 16,
   parameter logic [ADDR_W-1:0] SEL_PORT  = ADDR_W'(16'h0CF8),
   parameter logic [ADDR_W-1:0] WIN_PORT  = ADDR_W'(16'h0CFC),
   parameter logic [4:0]        LOCAL_DEV = 5'd3
) (
   input  logic              io_req,
   input  logic [ADDR_W-3:0] io_dw,
   input  logic [3:0]        io_be,
   input  cfg_sel_t          sel,
   output acc_kind_e         kind
);

   localparam logic [ADDR_W-3:0] SEL_DW = SEL_PORT[ADDR_W-1:2];
   localparam logic [ADDR_W-3:0] WIN_DW = WIN_PORT[ADDR_W-1:2];

   generate
      if (ADDR_W < 12) begin : g_bad_addr
         initial $fatal(1, "cfgm_host_decode: ADDR_W too small");
      end
      if (SEL_PORT[1:0] != 2'b00 || WIN_PORT[1:0] != 2'b00 || SEL_DW == WIN_DW) begin : g_bad_port
         initial $fatal(1, "cfgm_host_decode: ports must be distinct aligned dwords");
      end
   endgenerate

   logic sel_hit;
   logic win_hit;
   logic local_tgt;

   assign sel_hit   = (io_dw == SEL_DW) && (io_be == 4'hF);
   assign win_hit   = (io_dw == WIN_DW) && (io_be != 4'h0) && sel.en;
   assign local_tgt = (sel.bus == 8'd0) && (sel.dev == LOCAL_DEV);

   always_comb begin
      if (!io_req) begin
         kind = ACC_NONE;
      end else if (sel_hit) begin
         kind = ACC_SEL;
      end else if (win_hit) begin
         kind = local_tgt ? ACC_LOCAL : ACC_DS_CFG;
      end else begin
         kind = ACC_DS_IO;
      end
   end

endmodule

// File: rtl/cfgm_local_regs.sv
module cfgm_local_regs #(
   parameter int unsigned NUM_TEST   = 4,
   parameter int unsigned TEST_BASE  = 16,
   parameter logic [31:0] TEST_RESET = 32'h5A00_00A5,
   parameter logic [31:0] ID_VALUE   = 32'h1A2B_3C4D
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        acc,
   input  logic        wr,
   input  logic [2:0]  fn,
   input  logic [5:0]  regn,
   input  logic [3:0]  be,
   input  logic [31:0] wdata,
   output logic [31:0] rd_word
);

   generate
      if (NUM_TEST < 1 || TEST_BASE < 1 || TEST_BASE + NUM_TEST > 64) begin : g_bad_map
         initial $fatal(1, "cfgm_local_regs: test words must fit in dwords 1..63");
      end
   endgenerate

   logic [31:0] q [NUM_TEST];

   genvar gi, gl;
   generate
      for (gi = 0; gi < NUM_TEST; gi++) begin : g_word
         localparam logic [5:0] WORD_IDX = 6'(TEST_BASE + gi);
         logic hit;
         assign hit = acc && wr && (fn == 3'd0) && (regn == WORD_IDX);
         for (gl = 0; gl < 4; gl++) begin : g_lane
            always_ff @(posedge clk) begin
               if (!rst_n) begin
                  q[gi][gl*8 +: 8] <= TEST_RESET[gl*8 +: 8];
               end else if (hit && be[gl]) begin
                  q[gi][gl*8 +: 8] <= wdata[gl*8 +: 8];
               end
            end
         end
         // R8: a test word changes only when the host writes it
         a_r8_word_hold: assert property (@(posedge clk) disable iff (!rst_n)
            !(acc && wr) |=> $stable(q[gi]));
      end
   endgenerate

   always_comb begin
      rd_word = '0;
      if (fn == 3'd0) begin
         if (regn == 6'd0) begin
            rd_word = ID_VALUE;
         end
         for (int i = 0; i < NUM_TEST; i++) begin
            if (regn == 6'(TEST_BASE + i)) begin
               rd_word = q[i];
            end
         end
      end
   end

endmodule

// File: rtl/cfg_mech_decoder.sv
module cfg_mech_decoder
   import cfgm_pkg::*;
#(
   parameter int unsigned       ADDR_W     = 16,
   parameter logic [ADDR_W-1:0] SEL_PORT   = ADDR_W'(16'h0CF8),
   parameter logic [ADDR_W-1:0] WIN_PORT   = ADDR_W'(16'h0CFC),
   parameter logic [4:0]        LOCAL_DEV  = 5'd3,
   parameter int unsigned       NUM_TEST   = 4,
   parameter int unsigned       TEST_BASE  = 16,
   parameter logic [31:0]       TEST_RESET = 32'h5A00_00A5,
   parameter logic [31:0]       ID_VALUE   = 32'h1A2B_3C4D
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              io_req,
   input  logic              io_wr,
   input  logic [ADDR_W-1:0] io_addr,
   input  logic [3:0]        io_be,
   input  logic [31:0]       io_wdata,
   output logic              io_rdy,
   output logic [31:0]       io_rdata,
   output logic              ds_io_req,
   output logic              ds_cfg_req,
   output logic              ds_wr,
   output logic [ADDR_W-1:0] ds_addr,
   output logic [3:0]        ds_be,
   output logic [31:0]       ds_wdata,
   output logic [7:0]        ds_bus,
   output logic [4:0]        ds_dev,
   output logic [2:0]        ds_fn,
   output logic [5:0]        ds_reg
);

   acc_kind_e   kind;
   cfg_sel_t    sel;
   logic [31:0] sel_word;
   logic [31:0] loc_word;
   logic        sel_wr;
   logic        loc_acc;
   logic        fwd;

   assign sel_wr  = (kind == ACC_SEL) && io_wr;
   assign loc_acc = (kind == ACC_LOCAL);
   assign fwd     = (kind == ACC_DS_IO) || (kind == ACC_DS_CFG);

   cfgm_sel_reg #(.DATA_W(32)) u_sel (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (sel_wr),
      .wdata   (io_wdata),
      .sel     (sel),
      .rd_word (sel_word)
   );

   cfgm_host_decode #(
      .ADDR_W    (ADDR_W),
      .SEL_PORT  (SEL_PORT),
      .WIN_PORT  (WIN_PORT),
      .LOCAL_DEV (LOCAL_DEV)
   ) u_dec (
      .io_req (io_req),
      .io_dw  (io_addr[ADDR_W-1:2]),
      .io_be  (io_be),
      .sel    (sel),
      .kind   (kind)
   );

   cfgm_local_regs #(
      .NUM_TEST   (NUM_TEST),
      .TEST_BASE  (TEST_BASE),
      .TEST_RESET (TEST_RESET),
      .ID_VALUE   (ID_VALUE)
   ) u_loc (
      .clk     (clk),
      .rst_n   (rst_n),
      .acc     (loc_acc),
      .wr      (io_wr),
      .fn      (sel.fn),
      .regn    (sel.regn),
      .be      (io_be),
      .wdata   (io_wdata),
      .rd_word (loc_word)
   );

   logic [31:0] rdata_d;

   always_comb begin
      rdata_d = '0;
      if (!io_wr) begin
         unique case (kind)
            ACC_SEL:   rdata_d = sel_word;
            ACC_LOCAL: rdata_d = loc_word & lane_mask(io_be);
            default:   rdata_d = '0;
         endcase
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         io_rdy     <= 1'b0;
         io_rdata   <= '0;
         ds_io_req  <= 1'b0;
         ds_cfg_req <= 1'b0;
         ds_wr      <= 1'b0;
         ds_addr    <= '0;
         ds_be      <= '0;
         ds_wdata   <= '0;
         ds_bus     <= '0;
         ds_dev     <= '0;
         ds_fn      <= '0;
         ds_reg     <= '0;
      end else begin
         io_rdy     <= (kind != ACC_NONE);
         io_rdata   <= rdata_d;
         ds_io_req  <= (kind == ACC_DS_IO);
         ds_cfg_req <= (kind == ACC_DS_CFG);
         ds_wr      <= fwd ? io_wr    : 1'b0;
         ds_addr    <= fwd ? io_addr  : '0;
         ds_be      <= fwd ? io_be    : '0;
         ds_wdata   <= fwd ? io_wdata : '0;
         ds_bus     <= (kind == ACC_DS_CFG) ? sel.bus  : '0;
         ds_dev     <= (kind == ACC_DS_CFG) ? sel.dev  : '0;
         ds_fn      <= (kind == ACC_DS_CFG) ? sel.fn   : '0;
         ds_reg     <= (kind == ACC_DS_CFG) ? sel.regn : '0;
      end
   end

   // R10: every request is answered on the next edge
   a_r10_rdy_follows_req: assert property (@(posedge clk) disable iff (!rst_n)
      io_req |=> io_rdy);

   // R10: no ready pulse without a request one cycle before
   a_r10_rdy_has_cause: assert property (@(posedge clk) disable iff (!rst_n)
      io_rdy |-> $past(io_req));

   // R10: forwarded accesses return zero read data
   a_r10_fwd_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (ds_io_req || ds_cfg_req) |-> (io_rdata == 32'd0));

   // R6: at most one downstream target, and only with a ready pulse
   a_r6_one_target: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({ds_io_req, ds_cfg_req}) && ((ds_io_req || ds_cfg_req) -> io_rdy));

   // R6: a downstream configuration cycle never names the local device on bus 0
   a_r6_not_local: assert property (@(posedge clk) disable iff (!rst_n)
      ds_cfg_req |-> (ds_bus != 8'd0 || ds_dev != LOCAL_DEV));

endmodule

// File: tb/cfg_mech_decoder_test.sv
`timescale 1ns/1ps
module cfg_mech_decoder_test;

   localparam logic [4:0]  LD    = 5'd3;
   localparam int          TBASE = 16;
   localparam int          NT    = 4;
   localparam logic [31:0] TRST  = 32'h5A00_00A5;
   localparam logic [31:0] IDV   = 32'h1A2B_3C4D;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        io_req = 1'b0;
   logic        io_wr = 1'b0;
   logic [15:0] io_addr = '0;
   logic [3:0]  io_be = '0;
   logic [31:0] io_wdata = '0;
   logic        io_rdy;
   logic [31:0] io_rdata;
   logic        ds_io_req, ds_cfg_req, ds_wr;
   logic [15:0] ds_addr;
   logic [3:0]  ds_be;
   logic [31:0] ds_wdata;
   logic [7:0]  ds_bus;
   logic [4:0]  ds_dev;
   logic [2:0]  ds_fn;
   logic [5:0]  ds_reg;

   always #2.5 clk = ~clk;

   cfg_mech_decoder #(
      .ADDR_W(16), .LOCAL_DEV(LD), .NUM_TEST(NT), .TEST_BASE(TBASE),
      .TEST_RESET(TRST), .ID_VALUE(IDV)
   ) uut (
      .clk(clk), .rst_n(rst_n), .io_req(io_req), .io_wr(io_wr),
      .io_addr(io_addr), .io_be(io_be), .io_wdata(io_wdata),
      .io_rdy(io_rdy), .io_rdata(io_rdata),
      .ds_io_req(ds_io_req), .ds_cfg_req(ds_cfg_req), .ds_wr(ds_wr),
      .ds_addr(ds_addr), .ds_be(ds_be), .ds_wdata(ds_wdata),
      .ds_bus(ds_bus), .ds_dev(ds_dev), .ds_fn(ds_fn), .ds_reg(ds_reg)
   );

   int          n_chk = 0;
   int          n_err = 0;
   logic [31:0] m_sel = '0;
   logic [31:0] m_tw [NT];
   logic [31:0] last_rd;

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   function automatic logic [31:0] lanes(input logic [3:0] be);
      logic [31:0] m;
      for (int k = 0; k < 4; k++) m[k*8 +: 8] = {8{be[k]}};
      return m;
   endfunction

   function automatic logic [31:0] loc_word(input logic [2:0] fn, input logic [5:0] r);
      if (fn != 0) return 32'd0;
      if (r == 0) return IDV;
      if (r >= TBASE && r < TBASE + NT) return m_tw[r - TBASE];
      return 32'd0;
   endfunction

   function automatic string loc_tag(input logic [2:0] fn, input logic [5:0] r);
      if (fn != 0) return "R7";
      if (r == 0) return "R9";
      if (r >= TBASE && r < TBASE + NT) return "R8";
      return "R7";
   endfunction

   task automatic access(input logic wr, input logic [15:0] a, input logic [3:0] be,
                         input logic [31:0] wd);
      logic [13:0] dw;
      logic [7:0]  bus;
      logic [4:0]  dev;
      logic [2:0]  fn;
      logic [5:0]  r;
      int          kind;
      string       tag;
      logic [31:0] exp_rd;
      dw  = a[15:2];
      bus = m_sel[23:16];
      dev = m_sel[15:11];
      fn  = m_sel[10:8];
      r   = m_sel[7:2];
      exp_rd = '0;
      if (dw == 14'(16'h0CF8 >> 2) && be == 4'hF) begin
         kind = 0; tag = "R2";
         if (!wr) exp_rd = m_sel;
      end else if (dw == 14'(16'h0CFC >> 2) && be != 0 && m_sel[31]) begin
         if (bus == 0 && dev == LD) begin
            kind = 1; tag = loc_tag(fn, r);
            if (!wr) exp_rd = loc_word(fn, r) & lanes(be);
            if (!wr && (r != 0) && fn == 0 && !(r >= TBASE && r < TBASE + NT)) tag = "R7";
         end else begin
            kind = 2; tag = "R6";
         end
      end else begin
         kind = 3;
         if (dw == 14'(16'h0CF8 >> 2) && be != 0) tag = "R3";
         else if (dw == 14'(16'h0CFC >> 2) && be != 0) tag = "R4";
         else tag = "R11";
      end
      @(negedge clk);
      io_req = 1'b1; io_wr = wr; io_addr = a; io_be = be; io_wdata = wd;
      @(negedge clk);
      io_req = 1'b0;
      last_rd = io_rdata;
      chk("R10 rdy", 32'(io_rdy), 32'd1);
      chk({tag, " rdata"}, io_rdata, exp_rd);
      chk({tag, " ds_io_req"}, 32'(ds_io_req), 32'(kind == 3));
      chk({tag, " ds_cfg_req"}, 32'(ds_cfg_req), 32'(kind == 2));
      if (kind >= 2) begin
         chk({tag, " ds_wr"}, 32'(ds_wr), 32'(wr));
         chk({tag, " ds_be"}, 32'(ds_be), 32'(be));
         chk({tag, " ds_addr"}, 32'(ds_addr), 32'(a));
         if (wr) chk({tag, " ds_wdata"}, ds_wdata, wd);
      end
      if (kind == 2) begin
         chk("R6 fields", {9'd0, ds_bus, ds_dev, ds_fn, ds_reg}, {9'd0, bus, dev, fn, r});
      end
      if (kind == 0 && wr) m_sel = wd & 32'h80FF_FFFC;
      if (kind == 1 && wr && fn == 0 && r >= TBASE && r < TBASE + NT) begin
         for (int k = 0; k < 4; k++)
            if (be[k]) m_tw[r - TBASE][k*8 +: 8] = wd[k*8 +: 8];
      end
      @(negedge clk);
      chk("R10 pulse width", 32'(io_rdy), 32'd0);
   endtask

   function automatic logic [31:0] selw(input logic [7:0] bus, input logic [4:0] dev,
                                        input logic [2:0] fn, input logic [5:0] r);
      return {1'b1, 7'd0, bus, dev, fn, r, 2'b00};
   endfunction

   initial begin : watchdog
      repeat (200000) @(posedge clk);
      n_chk++; n_err++;
      $display("FAIL R10 watchdog actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end

   initial begin : main
      for (int i = 0; i < NT; i++) m_tw[i] = TRST;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state at the ports
      chk("R1 rdy idle", 32'(io_rdy), 32'd0);
      chk("R1 ds idle", 32'({ds_io_req, ds_cfg_req}), 32'd0);
      access(1'b0, 16'h0CF8, 4'hF, 32'd0);
      chk("R1 sel reset", last_rd, 32'd0);
      // R4: disabled window is forwarded
      for (int be = 1; be < 16; be++) begin
         access(1'b0, 16'h0CFC, 4'(be), 32'd0);
         access(1'b1, 16'h0CFC, 4'(be), 32'h1111_0000 + 32'(be));
      end
      // R1: test words at reset value
      for (int i = 0; i < NT; i++) begin
         access(1'b1, 16'h0CF8, 4'hF, selw(8'd0, LD, 3'd0, 6'(TBASE + i)));
         access(1'b0, 16'h0CFC, 4'hF, 32'd0);
         chk("R1 test word reset", last_rd, TRST);
      end
      // R2: selector patterns with reserved bits set
      for (int p = 0; p < 8; p++) begin
         logic [31:0] v;
         v = (p == 0) ? 32'hFFFF_FFFF : (32'h9E37_79B9 * 32'(p + 1)) ^ 32'(p << 29);
         access(1'b1, 16'h0CF8, 4'hF, v);
         access(1'b0, 16'h0CF8, 4'hF, 32'd0);
         chk("R2 readback", last_rd, v & 32'h80FF_FFFC);
      end
      // R3: partial accesses to the selector port
      access(1'b1, 16'h0CF8, 4'hF, 32'h8001_2304);
      for (int be = 1; be < 15; be++) begin
         access(1'b1, 16'h0CF8, 4'(be), 32'hFFFF_FFFF);
         access(1'b0, 16'h0CFA, 4'(be), 32'd0);
         access(1'b0, 16'h0CF8, 4'hF, 32'd0);
         chk("R3 selector unchanged", last_rd, 32'h8001_2304);
      end
      // R5 R7 R8 R9: walk the local function 0 space
      for (int r = 0; r < 64; r++) begin
         access(1'b1, 16'h0CF8, 4'hF, selw(8'd0, LD, 3'd0, 6'(r)));
         access(1'b0, 16'h0CFC, 4'hF, 32'd0);
         access(1'b1, 16'h0CFC, 4'((r % 15) + 1), 32'hC3A5_0000 ^ (32'(r) * 32'h0101_0101));
      end
      for (int r = 0; r < 64; r++) begin
         access(1'b1, 16'h0CF8, 4'hF, selw(8'd0, LD, 3'd0, 6'(r)));
         access(1'b0, 16'h0CFC, 4'hF, 32'd0);
      end
      // R5: lane sweep on one test word and on the identity word
      for (int be = 1; be < 16; be++) begin
         access(1'b1, 16'h0CF8, 4'hF, selw(8'd0, LD, 3'd0, 6'(TBASE + 1)));
         access(1'b0, 16'h0CFD, 4'(be), 32'd0);
         access(1'b1, 16'h0CF8, 4'hF, selw(8'd0, LD, 3'd0, 6'd0));
         access(1'b0, 16'h0CFC, 4'(be), 32'd0);
      end
      // R7: other functions of the local device
      for (int f = 1; f < 8; f++) begin
         access(1'b1, 16'h0CF8, 4'hF, selw(8'd0, LD, 3'(f), 6'(TBASE)));
         access(1'b1, 16'h0CFC, 4'hF, 32'hDEAD_BEEF);
         access(1'b0, 16'h0CFC, 4'hF, 32'd0);
         access(1'b1, 16'h0CF8, 4'hF, selw(8'd0, LD, 3'(f), 6'd0));
         access(1'b0, 16'h0CFC, 4'b0110, 32'd0);
      end
      access(1'b1, 16'h0CF8, 4'hF, selw(8'd0, LD, 3'd0, 6'(TBASE)));
      access(1'b0, 16'h0CFC, 4'hF, 32'd0);
      // R6: devices on other buses and other devices on bus 0
      for (int b = 0; b < 3; b++) begin
         for (int d = 0; d < 32; d++) begin
            logic [7:0] bus;
            bus = (b == 0) ? 8'd0 : (b == 1) ? 8'd1 : 8'hFF;
            if (!(bus == 0 && 5'(d) == LD)) begin
               access(1'b1, 16'h0CF8, 4'hF, selw(bus, 5'(d), 3'(d), 6'(d + b)));
               access(d[0], 16'h0CFC, 4'((d % 15) + 1), 32'h0BAD_0000 + 32'(d));
            end
         end
      end
      // R11: unrelated ports and empty byte enables
      access(1'b0, 16'h0080, 4'hF, 32'd0);
      access(1'b1, 16'h0CF4, 4'hF, 32'h1234_5678);
      access(1'b0, 16'h0D00, 4'h1, 32'd0);
      access(1'b1, 16'h0CF8, 4'h0, 32'hFFFF_FFFF);
      access(1'b0, 16'h0CFC, 4'h0, 32'd0);
      access(1'b0, 16'h0CF8, 4'hF, 32'd0);
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end

endmodule